// File: doc/BRIEF.md
# Constant-Coefficient Weighted Sum Compressor

This block forms the weighted sum Z = 4X + 3Y + 13 of two 3-bit unsigned operands and presents it as a 6-bit unsigned result. It contains no `+` operator. The network is built only from one-bit full-adder cells, fixed 0/1 ties and a single inverter. The two coefficients and the constant addend are placed into fixed bit columns. The columns are then reduced in carry-save fashion, so only five full-adder cells are needed.

The two lowest result bits are plain wiring. Adding 1 to Y's bit 0 gives a sum that is the inverse of that bit and a carry that equals it. The next column has two copies of Y's bit 0 plus Y's bit 1, so its sum is Y's bit 1 and its carry is Y's bit 0. Columns 2 and 3 each use two chained cells. Column 4 uses one cell, whose carry becomes the top result bit.

The block is purely combinational. A user drives the operands and reads the result in the same cycle, with whatever register stages the surrounding logic provides.

Top module: `wsum_compressor`

## Requirements
- R1: For every X and Y in 0..7, z_out equals 4*X + 3*Y + 13, read as an unsigned 6-bit value.
- R2: The result lies between 13 (X=Y=0) and 62 (X=Y=7), so it always fits in 6 bits.
- R3: z_out[0] equals the inverse of y_in[0] (bit 0 is the LSB).
- R4: z_out[1] equals y_in[1].
- R5: z_out[2] equals the inverted XOR of x_in[0], y_in[0], y_in[1] and y_in[2].
- R6: z_out[5] is 1 exactly when the sum is 32 or more.
- R7: The full-adder cell drives sum = a XOR b XOR cin and carry = majority(a, b, cin) for all 8 input patterns.
- R8: The block holds no state. A change on x_in or y_in shows up on z_out without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 3 | Operand X, weighted by 4 |
| y_in | input | 3 | Operand Y, weighted by 3 |
| z_out | output | 6 | Unsigned result 4X + 3Y + 13 |

## Verification
The operand widths are fixed at three bits, so all 64 (X, Y) pairs are driven. Each pair is checked against an integer reference and against the per-bit rules for the low columns and the top carry. The full-adder cell is also instantiated on its own and swept through all 8 input patterns. One input change between clock edges shows that the output settles without any clock.

// File: rtl/wsum_pkg.sv
package wsum_pkg;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned RES_W   = 6;
  localparam int unsigned COEF_X  = 4;
  localparam int unsigned COEF_Y  = 3;
  localparam int unsigned ADDEND  = 13;
  localparam int unsigned MAX_OP  = (1 << OP_W) - 1;
  localparam int unsigned RES_MIN = ADDEND;
  localparam int unsigned RES_MAX = COEF_X * MAX_OP + COEF_Y * MAX_OP + ADDEND;
  localparam int unsigned NUM_FA  = 5;
endpackage

// File: rtl/wsum_fa_cell.sv
module wsum_fa_cell (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  always_comb begin
    sum  = a ^ b ^ cin;
    cout = (a & b) | (a & cin) | (b & cin);
  end

  // R7: the pair (cout,sum) encodes the count of ones among the inputs
  always_comb begin
    if (!$isunknown({a, b, cin}))
      a_r7_fa_count: assert ({cout, sum} == 2'(a) + 2'(b) + 2'(cin))
        else $error("full adder count mismatch");
  end
endmodule

// File: rtl/wsum_low_cols.sv
module wsum_low_cols (
  input  logic y0,
  input  logic y1,
  output logic bit0,
  output logic bit1,
  output logic carry_out
);
  // column 0: y0 + 1 -> sum ~y0, carry y0 (the single inverter)
  // column 1: y1 + y0 + carry(y0) -> sum y1, carry y0
  always_comb begin
    bit0      = ~y0;
    bit1      = y1;
    carry_out = y0;
  end
endmodule

// File: rtl/wsum_compressor.sv
module wsum_compressor
  import wsum_pkg::*;
(
  input  logic [OP_W-1:0]  x_in,
  input  logic [OP_W-1:0]  y_in,
  output logic [RES_W-1:0] z_out
);
  localparam logic TIE_HI = 1'b1;

  logic c1_to_c2;
  logic s2a, c2a, c2b;
  logic s3a, c3a, c3b;

  wsum_low_cols u_low (
    .y0       (y_in[0]),
    .y1       (y_in[1]),
    .bit0     (z_out[0]),
    .bit1     (z_out[1]),
    .carry_out(c1_to_c2)
  );

  // column 2: x0, y1, y2, 1, carry from column 1
  wsum_fa_cell u_fa2a (.a(x_in[0]), .b(y_in[1]), .cin(y_in[2]), .sum(s2a),      .cout(c2a));
  wsum_fa_cell u_fa2b (.a(s2a),     .b(TIE_HI),  .cin(c1_to_c2), .sum(z_out[2]), .cout(c2b));

  // column 3: x1, y2, 1, two carries from column 2
  wsum_fa_cell u_fa3a (.a(x_in[1]), .b(y_in[2]), .cin(TIE_HI), .sum(s3a),      .cout(c3a));
  wsum_fa_cell u_fa3b (.a(s3a),     .b(c2a),     .cin(c2b),    .sum(z_out[3]), .cout(c3b));

  // column 4: x2 plus two carries from column 3; carry is the top bit
  wsum_fa_cell u_fa4 (.a(x_in[2]), .b(c3a), .cin(c3b), .sum(z_out[4]), .cout(z_out[5]));

  always_comb begin
    if (!$isunknown({x_in, y_in})) begin
      a_r1_weighted_sum: assert (int'(z_out) == COEF_X * int'(x_in) + COEF_Y * int'(y_in) + ADDEND)
        else $error("weighted sum mismatch");
      a_r2_in_range: assert (int'(z_out) >= RES_MIN && int'(z_out) <= RES_MAX)
        else $error("result out of range");
      a_r3_lsb_inverse: assert (z_out[0] != y_in[0])
        else $error("bit0 rule broken");
      a_r4_bit1_copy: assert (z_out[1] == y_in[1])
        else $error("bit1 rule broken");
      a_r5_bit2_parity: assert (z_out[2] == ~^{x_in[0], y_in})
        else $error("bit2 parity broken");
    end
  end
endmodule

// File: tb/wsum_compressor_tb.sv
`timescale 1ns/1ps
module wsum_compressor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0] x, y;
  logic [5:0] z;
  logic fa_a, fa_b, fa_c, fa_s, fa_co;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wsum_compressor u_dut (.x_in(x), .y_in(y), .z_out(z));
  wsum_fa_cell u_fa (.a(fa_a), .b(fa_b), .cin(fa_c), .sum(fa_s), .cout(fa_co));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    x = 0; y = 0; fa_a = 0; fa_b = 0; fa_c = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 zero operands", int'(z), 13);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        x = 3'(i); y = 3'(j);
        #1;
        begin
          int e;
          e = 4 * i + 3 * j + 13;
          check("R1 sum", int'(z), e);
          check("R2 range", int'(z >= 6'd13 && z <= 6'd62), 1);
          check("R3 bit0", int'(z[0]), int'(!(j & 1)));
          check("R4 bit1", int'(z[1]), (j >> 1) & 1);
          check("R5 bit2", int'(z[2]), 1 ^ ((i & 1) ^ (j & 1) ^ ((j >> 1) & 1) ^ ((j >> 2) & 1)));
          check("R6 top bit", int'(z[5]), int'(e >= 32));
        end
      end
    end
    check("R2 maximum", int'(z), 62);

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {fa_a, fa_b, fa_c} = 3'(k);
      #1;
      begin
        int ones;
        ones = (k & 1) + ((k >> 1) & 1) + ((k >> 2) & 1);
        check("R7 fa sum", int'(fa_s), ones & 1);
        check("R7 fa carry", int'(fa_co), int'(ones >= 2));
      end
    end

    @(posedge clk); #2;
    x = 3'd5; y = 3'd2;
    #1;
    check("R8 no clock", int'(z), 4 * 5 + 3 * 2 + 13);
    x = 3'd1; y = 3'd6;
    #1;
    check("R8 second change", int'(z), 4 * 1 + 3 * 6 + 13);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule